// File: doc/BRIEF.md
# UART Interrupt and FIFO Watermark Core

This block is the interrupt engine of a UART. It contains a byte-wide transmit FIFO of 32 entries and a byte-wide receive FIFO of 64 entries. Both FIFOs are first-word-fall-through: the byte at the head is visible on the read-data output before it is popped. The bus side pushes transmit bytes and pops receive bytes. The line side pops transmit bytes and pushes receive bytes. Two 3-bit level codes set a fill threshold for each FIFO.

Nine interrupt sources share one state vector. Three of them are live conditions that are recomputed from the FIFO fill levels on every cycle: transmit below threshold, receive at or above threshold, and transmit empty. The other six are sticky events that stay set until software clears them. Line errors enter as single-cycle pulses. The receive overflow and transmit done events come from the FIFOs themselves. Each interrupt line is its state bit gated by an enable bit.

A small register write port selects one of three targets. It can clear event bits with write-one-to-clear, load the enable mask, or load the FIFO control fields (two level codes and two reset strobes).

Top module: `uart_irq_core`

## Requirements
- R1: Each FIFO returns bytes in push order. A pop of an empty FIFO is ignored. A push into a full transmit FIFO is dropped unless it comes with a pop in the same cycle. A push and a pop together leave the fill count unchanged.
- R2: The transmit threshold is 2^code for codes 0 to 3 and 16 for codes 4 to 7. Bit 0 of the state vector (tx_watermark) is 1 while the transmit fill is below this threshold.
- R3: The receive threshold is 2^code for codes 0 to 5, 62 for code 6 and 127 for code 7. Bit 1 (rx_watermark) is 1 while the receive fill is at or above this threshold, so code 7 keeps it at 0.
- R4: Bits 0, 1 and 8 are live status bits (bit 8 is tx_empty: transmit fill is zero). A write-one-to-clear leaves them unchanged while their condition holds, and each bit falls on its own once its condition ends.
- R5: Event bits 2 to 7 are sticky. Bits 4 to 7 are set by the frame-error, break, timeout and parity pulses, in that order. A 1 written to an event bit through the state target clears it. A set and a clear of the same bit in the same cycle leave the bit set.
- R6: A receive push while the receive FIFO is full and not being popped drops the byte and sets bit 3 (rx_overflow).
- R7: Bit 2 (tx_done) is set when a line-side pop takes the transmit FIFO from one entry to empty with no push in the same cycle. It is also set by a transmit FIFO reset.
- R8: irq[i] equals state bit i AND enable bit i, for all nine bits.
- R9: A write to the FIFO control target loads these fields: bit 0 resets the receive FIFO, bit 1 resets the transmit FIFO, bits 4:2 hold the receive level code and bits 7:5 hold the transmit level code. A reset strobe wins over a push or pop in the same cycle. The state vector and the interrupt lines reflect the new fields and fills one edge after the write.
- R10: After reset, the enable mask and all event bits are 0, both FIFOs are empty and both level codes are 0. The state vector therefore reads 0x101.
- R11: Register target select codes are 0 for state (write-one-to-clear), 1 for enable (bits 8:0) and 2 for FIFO control. Code 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txPush | input | 1 | Bus-side push into the transmit FIFO |
| txWrData | input | 8 | Byte to push into the transmit FIFO |
| txPop | input | 1 | Line-side pop from the transmit FIFO |
| txRdData | output | 8 | Head byte of the transmit FIFO |
| rxPush | input | 1 | Line-side push into the receive FIFO |
| rxWrData | input | 8 | Received byte to push |
| rxPop | input | 1 | Bus-side pop from the receive FIFO |
| rxRdData | output | 8 | Head byte of the receive FIFO |
| frameErrPulse | input | 1 | Framing error event |
| breakErrPulse | input | 1 | Break detected event |
| timeoutPulse | input | 1 | Receive timeout event |
| parityErrPulse | input | 1 | Parity error event |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register target select |
| regWdata | input | 16 | Register write data |
| intrState | output | 9 | State vector: live status bits merged with latched event bits |
| irq | output | 9 | Per-source interrupt lines |

## Verification
Every push, pop, pulse and register write is sampled on one rising edge. Its effect on intrState and irq is due right after that same edge, because the status bits are combinational over registered fill counts and level codes. The head byte of each FIFO is valid before the edge that pops it. The bench drives inputs on the falling edge, compares the head bytes in that half cycle, and compares intrState and irq on the next falling edge against a model stepped once per edge.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NUM_IRQ = 9;

  localparam int IRQ_TX_WM   = 0;
  localparam int IRQ_RX_WM   = 1;
  localparam int IRQ_TX_DONE = 2;
  localparam int IRQ_RX_OVF  = 3;
  localparam int IRQ_FRAME   = 4;
  localparam int IRQ_BREAK   = 5;
  localparam int IRQ_TOUT    = 6;
  localparam int IRQ_PARITY  = 7;
  localparam int IRQ_TX_EMPTY = 8;

  localparam logic [NUM_IRQ-1:0] EVT_MASK = 9'h0FC;

  typedef enum logic [1:0] {
    SEL_STATE  = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_FIFO   = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic txClr;
    logic rxClr;
  } fifoStrobe_t;
endpackage

// File: rtl/uirq_fifo.sv
module uirq_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic          pop,
  input  logic          clr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic [CW-1:0] count,
  output logic          pushDrop
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wPtr, rPtr;
  logic doPush, doPop;

  assign doPop    = pop && (count != '0);
  assign doPush   = push && ((count != FULL_CNT) || doPop);
  assign pushDrop = push && !doPush;
  assign rdData   = mem[rPtr];

  always_ff @(posedge clk) begin
    if (doPush && !clr) mem[wPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wPtr  <= '0;
      rPtr  <= '0;
      count <= '0;
    end else if (clr) begin
      wPtr  <= '0;
      rPtr  <= '0;
      count <= '0;
    end else begin
      if (doPush) wPtr <= (wPtr == LAST_IDX) ? '0 : wPtr + 1'b1;
      if (doPop)  rPtr <= (rPtr == LAST_IDX) ? '0 : rPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  // R1: fill never exceeds the depth
  p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R1: push with pop on a non-empty FIFO keeps the fill
  p_pushpop_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (push && pop && count != '0 && !clr) |=> $stable(count));

  // R9: a reset strobe empties the FIFO
  p_clr_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (count == '0));
endmodule

// File: rtl/uirq_datapath.sv
module uirq_datapath
  import uirq_pkg::*;
#(
  parameter int TX_DEPTH = 32,
  parameter int RX_DEPTH = 64,
  localparam int TX_CW = $clog2(TX_DEPTH + 1),
  localparam int RX_CW = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strobe,
  input  logic [7:0]       txWrData,
  input  logic [7:0]       rxWrData,
  output logic [7:0]       txRdData,
  output logic [7:0]       rxRdData,
  output logic [TX_CW-1:0] txCount,
  output logic [RX_CW-1:0] rxCount,
  output logic             rxDrop
);
  logic txDropUnused;

  uirq_fifo #(.DEPTH(TX_DEPTH), .DW(8)) u_txFifo (
    .clk(clk), .rstN(rstN),
    .push(strobe.txPush), .pop(strobe.txPop), .clr(strobe.txClr),
    .wrData(txWrData), .rdData(txRdData), .count(txCount),
    .pushDrop(txDropUnused)
  );

  uirq_fifo #(.DEPTH(RX_DEPTH), .DW(8)) u_rxFifo (
    .clk(clk), .rstN(rstN),
    .push(strobe.rxPush), .pop(strobe.rxPop), .clr(strobe.rxClr),
    .wrData(rxWrData), .rdData(rxRdData), .count(rxCount),
    .pushDrop(rxDrop)
  );
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
#(
  parameter int TX_DEPTH = 32,
  parameter int RX_DEPTH = 64,
  localparam int TX_CW  = $clog2(TX_DEPTH + 1),
  localparam int RX_CW  = $clog2(RX_DEPTH + 1),
  localparam int THW    = $clog2(2 * RX_DEPTH),
  localparam int TX_SAT = $clog2(TX_DEPTH) - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txPush,
  input  logic               txPop,
  input  logic               rxPush,
  input  logic               rxPop,
  input  logic               frameErrPulse,
  input  logic               breakErrPulse,
  input  logic               timeoutPulse,
  input  logic               parityErrPulse,
  input  logic               regWe,
  input  logic [1:0]         regSel,
  input  logic [15:0]        regWdata,
  input  logic [TX_CW-1:0]   txCount,
  input  logic [RX_CW-1:0]   rxCount,
  input  logic               rxDrop,
  output fifoStrobe_t        strobe,
  output logic [NUM_IRQ-1:0] intrState,
  output logic [NUM_IRQ-1:0] irq
);
  logic [2:0] txLvl, rxLvl;
  logic [NUM_IRQ-1:0] evt, evtNext, enable, setMask, clrMask, status;
  logic [THW-1:0] txThr, rxThr;
  logic wrState, wrEnable, wrFifo, txDrain;

  function automatic logic [THW-1:0] txThreshold(input logic [2:0] code);
    if (int'(code) >= TX_SAT) return THW'(TX_DEPTH / 2);
    return THW'(1) << code;
  endfunction

  function automatic logic [THW-1:0] rxThreshold(input logic [2:0] code);
    if (code == 3'd7) return THW'(2 * RX_DEPTH - 1);
    if (code == 3'd6) return THW'(RX_DEPTH - 2);
    return THW'(1) << code;
  endfunction

  assign wrState  = regWe && (regSel_e'(regSel) == SEL_STATE);
  assign wrEnable = regWe && (regSel_e'(regSel) == SEL_ENABLE);
  assign wrFifo   = regWe && (regSel_e'(regSel) == SEL_FIFO);

  always_comb begin
    strobe.txPush = txPush;
    strobe.txPop  = txPop;
    strobe.rxPush = rxPush;
    strobe.rxPop  = rxPop;
    strobe.rxClr  = wrFifo && regWdata[0];
    strobe.txClr  = wrFifo && regWdata[1];
  end

  assign txDrain = txPop && (txCount == TX_CW'(1)) && !txPush;

  always_comb begin
    setMask = '0;
    setMask[IRQ_TX_DONE] = txDrain || strobe.txClr;
    setMask[IRQ_RX_OVF]  = rxDrop;
    setMask[IRQ_FRAME]   = frameErrPulse;
    setMask[IRQ_BREAK]   = breakErrPulse;
    setMask[IRQ_TOUT]    = timeoutPulse;
    setMask[IRQ_PARITY]  = parityErrPulse;
    clrMask = wrState ? (regWdata[NUM_IRQ-1:0] & EVT_MASK) : '0;
    evtNext = ((evt & ~clrMask) | setMask) & EVT_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evt    <= '0;
      enable <= '0;
      txLvl  <= '0;
      rxLvl  <= '0;
    end else begin
      evt <= evtNext;
      if (wrEnable) enable <= regWdata[NUM_IRQ-1:0];
      if (wrFifo) begin
        rxLvl <= regWdata[4:2];
        txLvl <= regWdata[7:5];
      end
    end
  end

  assign txThr = txThreshold(txLvl);
  assign rxThr = rxThreshold(rxLvl);

  always_comb begin
    status = '0;
    status[IRQ_TX_WM]    = THW'(txCount) < txThr;
    status[IRQ_RX_WM]    = THW'(rxCount) >= rxThr;
    status[IRQ_TX_EMPTY] = (txCount == '0);
  end

  assign intrState = evt | status;
  assign irq       = intrState & enable;

  // R3: code 7 keeps rx_watermark low
  p_rx_wm_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rxLvl == 3'd7) |-> !intrState[IRQ_RX_WM]);

  // R4: empty transmit FIFO always shows tx_empty and tx_watermark
  p_tx_empty_live_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txCount == '0) |-> (intrState[IRQ_TX_EMPTY] && intrState[IRQ_TX_WM]));

  // R5: an event bit stays set unless a clear hits it
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (intrState[IRQ_FRAME] && !(wrState && regWdata[IRQ_FRAME])) |=> intrState[IRQ_FRAME]);

  // R6: a dropped receive byte raises rx_overflow
  p_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxDrop |=> intrState[IRQ_RX_OVF]);

  // R7: transmit reset raises tx_done
  p_done_on_clr_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txClr |=> intrState[IRQ_TX_DONE]);

  // R8: no line rises without its enable
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irq & ~enable) == '0);
endmodule

// File: rtl/uart_irq_core.sv
module uart_irq_core
  import uirq_pkg::*;
#(
  parameter int TX_DEPTH = 32,
  parameter int RX_DEPTH = 64,
  localparam int TX_CW = $clog2(TX_DEPTH + 1),
  localparam int RX_CW = $clog2(RX_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        txPush,
  input  logic [7:0]  txWrData,
  input  logic        txPop,
  output logic [7:0]  txRdData,
  input  logic        rxPush,
  input  logic [7:0]  rxWrData,
  input  logic        rxPop,
  output logic [7:0]  rxRdData,
  input  logic        frameErrPulse,
  input  logic        breakErrPulse,
  input  logic        timeoutPulse,
  input  logic        parityErrPulse,
  input  logic        regWe,
  input  logic [1:0]  regSel,
  input  logic [15:0] regWdata,
  output logic [8:0]  intrState,
  output logic [8:0]  irq
);
  fifoStrobe_t      strobe;
  logic [TX_CW-1:0] txCount;
  logic [RX_CW-1:0] rxCount;
  logic             rxDrop;

  uirq_ctrl #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .txPush(txPush), .txPop(txPop), .rxPush(rxPush), .rxPop(rxPop),
    .frameErrPulse(frameErrPulse), .breakErrPulse(breakErrPulse),
    .timeoutPulse(timeoutPulse), .parityErrPulse(parityErrPulse),
    .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .txCount(txCount), .rxCount(rxCount), .rxDrop(rxDrop),
    .strobe(strobe), .intrState(intrState), .irq(irq)
  );

  uirq_datapath #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txWrData(txWrData), .rxWrData(rxWrData),
    .txRdData(txRdData), .rxRdData(rxRdData),
    .txCount(txCount), .rxCount(rxCount), .rxDrop(rxDrop)
  );
endmodule

// File: tb/uart_irq_core_tb.sv
module uart_irq_core_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic txPush, txPop, rxPush, rxPop;
  logic [7:0] txWrData, rxWrData, txRdData, rxRdData;
  logic frameErrPulse, breakErrPulse, timeoutPulse, parityErrPulse;
  logic regWe;
  logic [1:0] regSel;
  logic [15:0] regWdata;
  logic [8:0] intrState, irq;

  uart_irq_core u_dut (
    .clk(clk), .rstN(rstN),
    .txPush(txPush), .txWrData(txWrData), .txPop(txPop), .txRdData(txRdData),
    .rxPush(rxPush), .rxWrData(rxWrData), .rxPop(rxPop), .rxRdData(rxRdData),
    .frameErrPulse(frameErrPulse), .breakErrPulse(breakErrPulse),
    .timeoutPulse(timeoutPulse), .parityErrPulse(parityErrPulse),
    .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .intrState(intrState), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  logic [8:0] mEv, mEn;
  logic [2:0] mTxLvl, mRxLvl;

  function automatic int txThr(input logic [2:0] c);
    return (c >= 3'd4) ? 16 : (1 << c);
  endfunction

  function automatic int rxThr(input logic [2:0] c);
    if (c == 3'd7) return 127;
    if (c == 3'd6) return 62;
    return 1 << c;
  endfunction

  function automatic logic [8:0] expState();
    logic [8:0] s;
    s = mEv;
    s[0] = txQ.size() < txThr(mTxLvl);
    s[1] = rxQ.size() >= rxThr(mRxLvl);
    s[8] = txQ.size() == 0;
    return s;
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    txPush = 0; txPop = 0; rxPush = 0; rxPop = 0;
    txWrData = 0; rxWrData = 0;
    frameErrPulse = 0; breakErrPulse = 0; timeoutPulse = 0; parityErrPulse = 0;
    regWe = 0; regSel = 2'd3; regWdata = 0;
  endtask

  // one edge: head data checked before it, model advanced, outputs checked after
  task automatic step();
    logic [8:0] nEv, nEn;
    bit txPopOk, txPushOk, rxPopOk, rxPushOk, drain;
    if (txPop && txQ.size() > 0) chk("R1", "tx head", txRdData, txQ[0]);
    if (rxPop && rxQ.size() > 0) chk("R1", "rx head", rxRdData, rxQ[0]);
    nEv = mEv; nEn = mEn;
    if (regWe && regSel == 2'd0) nEv = nEv & ~(regWdata[8:0] & 9'h0FC);
    if (regWe && regSel == 2'd1) nEn = regWdata[8:0];
    txPopOk  = txPop && txQ.size() > 0;
    txPushOk = txPush && (txQ.size() < 32 || txPopOk);
    rxPopOk  = rxPop && rxQ.size() > 0;
    rxPushOk = rxPush && (rxQ.size() < 64 || rxPopOk);
    drain = txPopOk && !txPushOk && txQ.size() == 1;
    if (drain) nEv[2] = 1;
    if (rxPush && !rxPushOk) nEv[3] = 1;
    if (frameErrPulse) nEv[4] = 1;
    if (breakErrPulse) nEv[5] = 1;
    if (timeoutPulse) nEv[6] = 1;
    if (parityErrPulse) nEv[7] = 1;
    if (txPopOk) void'(txQ.pop_front());
    if (txPushOk) txQ.push_back(txWrData);
    if (rxPopOk) void'(rxQ.pop_front());
    if (rxPushOk) rxQ.push_back(rxWrData);
    if (regWe && regSel == 2'd2) begin
      mRxLvl = regWdata[4:2];
      mTxLvl = regWdata[7:5];
      if (regWdata[0]) rxQ.delete();
      if (regWdata[1]) begin txQ.delete(); nEv[2] = 1; end
    end
    @(posedge clk);
    mEv = nEv; mEn = nEn;
    @(negedge clk);
    chk("R4 R5", "intrState", intrState, expState());
    chk("R8", "irq", irq, expState() & mEn);
    idle();
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [15:0] d);
    regWe = 1; regSel = sel; regWdata = d;
    step();
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    mEv = 0; mEn = 0; mTxLvl = 0; mRxLvl = 0;
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R10", "reset state", intrState, 9'h101);
    chk("R10", "reset irq", irq, 0);

    regWrite(2'd1, 16'h01FF);
    chk("R8", "enabled irq", irq, 9'h101);
    regWrite(2'd0, 16'h01FF);
    chk("R4", "status bits survive clear", intrState, 9'h101);
    regWrite(2'd3, 16'h0000);
    chk("R11", "select 3 no effect", irq, 9'h101);

    // rx code 7: never reaches threshold
    regWrite(2'd2, 16'h001C);
    for (int i = 0; i < 64; i++) begin
      rxPush = 1; rxWrData = 8'(i * 3 + 1); step();
    end
    chk("R3", "code 7 disables rx wm", intrState[1], 0);
    rxPush = 1; rxWrData = 8'hEE; step();
    chk("R6", "overflow set", intrState[3], 1);
    rxPush = 1; rxPop = 1; rxWrData = 8'h55; step();
    chk("R1", "push+pop at full keeps overflow quiet", intrState[3], 1);
    regWrite(2'd0, 16'h0008);
    chk("R5", "overflow cleared", intrState[3], 0);
    regWrite(2'd2, 16'h0018);
    chk("R3", "code 6 at 64 fill", intrState[1], 1);
    for (int i = 0; i < 3; i++) begin rxPop = 1; step(); end
    chk("R4", "rx wm drops below 62", intrState[1], 0);
    regWrite(2'd2, 16'h0001);
    chk("R9", "rx reset empties", intrState[1], 0);

    // tx level and drain
    regWrite(2'd2, 16'h0060);
    for (int i = 0; i < 3; i++) begin txPush = 1; txWrData = 8'(8'hA0 + i); step(); end
    chk("R2", "3 below threshold 8", intrState[0], 1);
    chk("R4", "tx not empty", intrState[8], 0);
    for (int i = 0; i < 3; i++) begin txPop = 1; step(); end
    chk("R7", "drain sets done", intrState[2], 1);
    regWrite(2'd0, 16'h0004);
    chk("R7", "done cleared", intrState[2], 0);
    for (int i = 0; i < 20; i++) begin txPush = 1; txWrData = 8'(i); step(); end
    regWrite(2'd2, 16'h00E0);
    chk("R2", "code 7 saturates at 16", intrState[0], 0);
    regWrite(2'd2, 16'h00E2);
    chk("R9", "tx reset done and empty", intrState & 9'h105, 9'h105);

    // set wins over clear
    frameErrPulse = 1; regWe = 1; regSel = 2'd0; regWdata = 16'h0010; step();
    chk("R5", "set beats clear", intrState[4], 1);

    // random phase
    for (int ph = 0; ph < 40; ph++) begin
      int pushBias = (ph % 2 == 0) ? 80 : 25;
      for (int c = 0; c < 100; c++) begin
        txPush = ($urandom % 100) < pushBias; txWrData = 8'($urandom);
        txPop  = ($urandom % 100) < (100 - pushBias);
        rxPush = ($urandom % 100) < pushBias; rxWrData = 8'($urandom);
        rxPop  = ($urandom % 100) < (100 - pushBias);
        frameErrPulse  = ($urandom % 50) == 0;
        breakErrPulse  = ($urandom % 50) == 0;
        timeoutPulse   = ($urandom % 50) == 0;
        parityErrPulse = ($urandom % 50) == 0;
        if (($urandom % 20) == 0) begin
          regWe = 1; regSel = 2'($urandom);
          regWdata = 16'($urandom);
          if (regSel == 2'd2 && ($urandom % 4) != 0) regWdata[1:0] = 2'b00;
        end
        step();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule